// File: doc/BRIEF.md
# Wiper Position Register with Step Control

This block holds the control word for one digitally adjusted resistor divider. The word has three fields. The low six bits are the tap position. The next bit up isolates the wiper. The top bit links this array to its neighbour so that the two act as one longer chain. The register decodes the position into a one-hot vector that closes exactly one tap switch. When the isolate bit is set, that vector is held at zero and the wiper-enable output is low.

The word can change in four ways:
- On the first clock after reset it takes the stored value of the first data register, `dr0_i`.
- It can be loaded in parallel from a selected data register.
- It can be loaded serially, as a byte assembled by the host bus logic.
- It can be moved one tap per step strobe, with the direction given by the sampled data line.

When the cascade bit is clear, stepping stops at the ends of the range. When the cascade bit is set, stepping rolls over so the position can pass into the adjacent array.

The bus protocol engine sits outside this block and supplies the strobes. The analog array also sits outside and consumes `sel_o`.

Top module: `wiper_reg`

## Requirements
- R1: While reset is asserted `wcr_o` reads 00h. On the first rising clock after reset is released, `wcr_o` takes the value on `dr0_i`.
- R2: In that first cycle after reset, the recall of `dr0_i` outranks any parallel load, serial load or step presented at the same time.
- R3: At any other time, a clock edge with `par_ld_i` high loads `par_data_i` into the register. This outranks a serial load and a step in the same cycle.
- R4: A clock edge with `ser_ld_i` high and `par_ld_i` low loads `ser_data_i`. This outranks a step in the same cycle.
- R5: A clock edge with `step_i` high, no load pending and `step_up_i` high raises the position (bits 5..0) by exactly one. Bits 7 and 6 stay unchanged. A step that coincides with any load has no effect.
- R6: A clock edge with `step_i` high, no load pending and `step_up_i` low lowers the position by exactly one. Bits 7 and 6 stay unchanged.
- R7: With bit 7 clear, a step up at position 3Fh leaves the position at 3Fh, and a step down at 00h leaves it at 00h.
- R8: With bit 7 set, a step up at 3Fh gives 00h, and a step down at 00h gives 3Fh.
- R9: With bit 6 clear, `sel_o` has exactly one bit set, at index equal to bits 5..0. Index 0 is the low terminal and index 63 is the high terminal.
- R10: With bit 6 set, `sel_o` is all zero and `wiper_en_o` is low. With bit 6 clear, `wiper_en_o` is high.
- R11: `cascade_o` equals bit 7 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr0_i | input | 8 | Stored value recalled on the first cycle after reset |
| par_ld_i | input | 1 | Parallel load strobe |
| par_data_i | input | 8 | Parallel load data from the selected data register |
| ser_ld_i | input | 1 | Serial (host byte) load strobe |
| ser_data_i | input | 8 | Byte assembled from the host bus |
| step_i | input | 1 | One-cycle step strobe, one per bus clock pulse |
| step_up_i | input | 1 | Step direction: 1 toward the high terminal, 0 toward the low terminal |
| wcr_o | output | 8 | Current register contents |
| sel_o | output | 64 | One-hot tap switch enables |
| wiper_en_o | output | 1 | Wiper connected when high |
| cascade_o | output | 1 | Cascade mode flag |

## Verification
The bench goes after several corner cases, each of which a faulty design would expose:
- **Ends of the tap range in both modes.** A design that wraps when it should saturate would jump the wiper from one terminal to the other. A design that saturates in cascade mode would leave the wiper stuck at the array boundary.
- **Every byte value with the isolate bit set and clear.** An encoder that ignores the isolate bit would leave a tap switch closed on a floating wiper. A misplaced decode would close the wrong switch.
- **Same-cycle contention among recall, loads and steps.** A wrong priority would let a step corrupt a freshly loaded value, or let a bus write override the power-up recall.
- **Step moves with control bits set.** A step that forgets the upper bits would silently clear cascade or isolate.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   typedef enum logic [2:0] {
      SRC_HOLD,
      SRC_RECALL,
      SRC_PAR,
      SRC_SER,
      SRC_STEP
   } wsrc_e;
endpackage

// File: rtl/wiper_load_arb.sv
module wiper_load_arb
   import wiper_pkg::*;
(
   input  logic  recall_i,
   input  logic  par_i,
   input  logic  ser_i,
   input  logic  step_i,
   output wsrc_e src_o
);
   // Fixed priority: recall, parallel, serial, step.
   always_comb begin
      if (recall_i)    src_o = SRC_RECALL;
      else if (par_i)  src_o = SRC_PAR;
      else if (ser_i)  src_o = SRC_SER;
      else if (step_i) src_o = SRC_STEP;
      else             src_o = SRC_HOLD;
   end
endmodule

// File: rtl/wiper_step.sv
module wiper_step #(
   parameter int POS_W = 6
) (
   input  logic [POS_W-1:0] pos_i,
   input  logic             up_i,
   input  logic             wrap_i,
   output logic [POS_W-1:0] pos_o
);
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] POS_MIN = '0;
   localparam logic [POS_W-1:0] ONE     = POS_W'(1);

   logic at_top, at_bot;
   assign at_top = (pos_i == POS_MAX);
   assign at_bot = (pos_i == POS_MIN);

   // Saturate at the ends unless wrapping is allowed.
   always_comb begin
      if (up_i) begin
         if (at_top && !wrap_i) pos_o = POS_MAX;
         else                   pos_o = pos_i + ONE;
      end else begin
         if (at_bot && !wrap_i) pos_o = POS_MIN;
         else                   pos_o = pos_i - ONE;
      end
   end
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
   parameter int POS_W = 6
) (
   input  logic [POS_W-1:0]        pos_i,
   input  logic                    en_i,
   output logic [(1<<POS_W)-1:0]   sel_o
);
   localparam int TAPS = 1 << POS_W;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign sel_o[t] = en_i && (pos_i == POS_W'(t));
   end
endmodule

// File: rtl/wiper_reg.sv
module wiper_reg
   import wiper_pkg::*;
#(
   parameter int POS_W            = 6,
   parameter bit WRAP_IN_CASCADE  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [POS_W+1:0]       dr0_i,
   input  logic                   par_ld_i,
   input  logic [POS_W+1:0]       par_data_i,
   input  logic                   ser_ld_i,
   input  logic [POS_W+1:0]       ser_data_i,
   input  logic                   step_i,
   input  logic                   step_up_i,
   output logic [POS_W+1:0]       wcr_o,
   output logic [(1<<POS_W)-1:0]  sel_o,
   output logic                   wiper_en_o,
   output logic                   cascade_o
);
   localparam int DATA_W = POS_W + 2;
   localparam int TAPS   = 1 << POS_W;
   localparam int DW_BIT = POS_W;
   localparam int CM_BIT = POS_W + 1;
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

   if (POS_W < 1 || POS_W > 8) begin : g_bad_width
      $error("wiper_reg: POS_W must lie in 1..8");
   end

   logic [DATA_W-1:0] wcr_q, wcr_d;
   logic              recall_pend_q;
   logic [POS_W-1:0]  pos_step;
   logic              wrap_ok;
   wsrc_e             src;

   if (WRAP_IN_CASCADE) begin : g_wrap
      assign wrap_ok = wcr_q[CM_BIT];
   end else begin : g_sat
      assign wrap_ok = 1'b0;
   end

   wiper_load_arb u_arb (
      .recall_i (recall_pend_q),
      .par_i    (par_ld_i),
      .ser_i    (ser_ld_i),
      .step_i   (step_i),
      .src_o    (src)
   );

   wiper_step #(.POS_W(POS_W)) u_step (
      .pos_i  (wcr_q[POS_W-1:0]),
      .up_i   (step_up_i),
      .wrap_i (wrap_ok),
      .pos_o  (pos_step)
   );

   always_comb begin
      unique case (src)
         SRC_RECALL: wcr_d = dr0_i;
         SRC_PAR:    wcr_d = par_data_i;
         SRC_SER:    wcr_d = ser_data_i;
         SRC_STEP:   wcr_d = {wcr_q[DATA_W-1:POS_W], pos_step};
         default:    wcr_d = wcr_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcr_q         <= '0;
         recall_pend_q <= 1'b1;
      end else begin
         wcr_q         <= wcr_d;
         recall_pend_q <= 1'b0;
      end
   end

   wiper_decode #(.POS_W(POS_W)) u_dec (
      .pos_i (wcr_q[POS_W-1:0]),
      .en_i  (!wcr_q[DW_BIT]),
      .sel_o (sel_o)
   );

   assign wcr_o      = wcr_q;
   assign wiper_en_o = !wcr_q[DW_BIT];
   assign cascade_o  = wcr_q[CM_BIT];

   logic step_only;
   assign step_only = !recall_pend_q && !par_ld_i && !ser_ld_i && step_i;

   AST_RECALL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      recall_pend_q |=> (wcr_o == $past(dr0_i)));                        // R1
   AST_RECALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (recall_pend_q && (par_ld_i || ser_ld_i || step_i)) |=> (wcr_o == $past(dr0_i))); // R2
   AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_pend_q && par_ld_i) |=> (wcr_o == $past(par_data_i)));   // R3
   AST_SER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_pend_q && !par_ld_i && ser_ld_i) |=> (wcr_o == $past(ser_data_i))); // R4
   AST_STEP_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      step_only |=> $stable(wcr_o[DATA_W-1:POS_W]));                     // R5
   AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_only && step_up_i && !wcr_o[CM_BIT] && wcr_o[POS_W-1:0] == POS_MAX)
      |=> (wcr_o[POS_W-1:0] == POS_MAX));                                // R7
   AST_SAT_BOT: assert property (@(posedge clk) disable iff (!rst_n)
      (step_only && !step_up_i && !wcr_o[CM_BIT] && wcr_o[POS_W-1:0] == '0)
      |=> (wcr_o[POS_W-1:0] == '0));                                     // R7
   AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
      !wcr_o[DW_BIT] |-> ($countones(sel_o) == 1 && sel_o[wcr_o[POS_W-1:0]])); // R9
   AST_FLOAT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      wcr_o[DW_BIT] |-> (sel_o == '0 && !wiper_en_o));                   // R10

   localparam int UNUSED_TAPS = TAPS;
endmodule

// File: tb/wiper_reg_tb.sv
module wiper_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  dr0_i, par_data_i, ser_data_i;
   logic        par_ld_i, ser_ld_i, step_i, step_up_i;
   logic [7:0]  wcr_o;
   logic [63:0] sel_o;
   logic        wiper_en_o, cascade_o;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;   // 50 MHz

   wiper_reg u_dut (
      .clk(clk), .rst_n(rst_n), .dr0_i(dr0_i),
      .par_ld_i(par_ld_i), .par_data_i(par_data_i),
      .ser_ld_i(ser_ld_i), .ser_data_i(ser_data_i),
      .step_i(step_i), .step_up_i(step_up_i),
      .wcr_o(wcr_o), .sel_o(sel_o),
      .wiper_en_o(wiper_en_o), .cascade_o(cascade_o)
   );

   function automatic logic [63:0] exp_sel(input logic [7:0] v);
      return v[6] ? 64'd0 : (64'd1 << v[5:0]);
   endfunction

   function automatic logic [7:0] exp_step(input logic [7:0] v, input logic up);
      logic [5:0] p;
      p = v[5:0];
      if (up) p = (p == 6'h3F) ? (v[7] ? 6'h00 : 6'h3F) : p + 6'd1;
      else    p = (p == 6'h00) ? (v[7] ? 6'h3F : 6'h00) : p - 6'd1;
      return {v[7:6], p};
   endfunction

   task automatic check(input string req, input logic [7:0] e);
      n_tests++;
      if (wcr_o !== e || sel_o !== exp_sel(e) || wiper_en_o !== !e[6] || cascade_o !== e[7]) begin
         n_fail++;
         $display("FAIL %s: wcr=%02h sel=%016h en=%b cm=%b expected wcr=%02h sel=%016h en=%b cm=%b",
                  req, wcr_o, sel_o, wiper_en_o, cascade_o, e, exp_sel(e), !e[6], e[7]);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge.
   task automatic cyc(input logic pl, input logic [7:0] pd, input logic sl,
                      input logic [7:0] sd, input logic st, input logic up);
      par_ld_i = pl; par_data_i = pd; ser_ld_i = sl; ser_data_i = sd;
      step_i = st; step_up_i = up;
      @(negedge clk);
      par_ld_i = 1'b0; ser_ld_i = 1'b0; step_i = 1'b0;
   endtask

   initial begin
      #(20ns * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] e;
      rst_n = 1'b0; dr0_i = 8'h25;
      par_ld_i = 0; ser_ld_i = 0; step_i = 0; step_up_i = 0;
      par_data_i = 0; ser_data_i = 0;
      repeat (3) @(negedge clk);
      check("R1 reset state", 8'h00);

      // R1/R2: release reset with every competing request present.
      rst_n = 1'b1;
      cyc(1'b1, 8'h11, 1'b1, 8'h22, 1'b1, 1'b1);
      check("R2 recall beats loads", 8'h25);
      check("R1 recall dr0", 8'h25);

      // R3: parallel beats serial and step.
      cyc(1'b1, 8'h9A, 1'b1, 8'h33, 1'b1, 1'b0);
      check("R3 par priority", 8'h9A);
      // R4: serial beats step (step ignored).
      cyc(1'b0, 8'h00, 1'b1, 8'h4C, 1'b1, 1'b1);
      check("R4 ser over step", 8'h4C);

      // R5: consecutive steps, one per cycle.
      cyc(1'b1, 8'h8A, 1'b0, 8'h00, 1'b0, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
      check("R5 three steps up", 8'h8D);
      for (int k = 0; k < 5; k++) cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0);
      check("R6 five steps down", 8'h88);

      // R9/R10/R11: every byte value through the serial path.
      for (int v = 0; v < 256; v++) begin
         cyc(1'b0, 8'h00, 1'b1, 8'(v), 1'b0, 1'b0);
         check("R9 R10 R11 decode sweep", 8'(v));
      end

      // R5..R8: single step up and down from every byte value.
      for (int v = 0; v < 256; v++) begin
         for (int d = 0; d < 2; d++) begin
            cyc(1'b1, 8'(v), 1'b0, 8'h00, 1'b0, 1'b0);
            cyc(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, d[0]);
            e = exp_step(8'(v), d[0]);
            if (v[5:0] == 6'h3F && d == 1 || v[5:0] == 6'h00 && d == 0)
               check(v[7] ? "R8 wrap at end" : "R7 saturate at end", e);
            else
               check(d == 1 ? "R5 step up" : "R6 step down", e);
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule